// File: doc/BRIEF.md
# Heterogeneous Five-Port Micro-Op Dispatch Arbiter

This block holds a small pool of waiting micro-operations and decides, every cycle, which of them leave for the execution ports. Each pool entry carries a valid flag, an operation class and an age value. A per-entry ready vector comes from the surrounding wakeup logic. The arbiter gives each of five ports at most one entry. It takes the oldest entry that is ready and of a class the port can execute, and it drops every dispatched entry from the pool at the next clock edge.

The ports are not alike. Port 0 serves both the full-function integer unit and the floating-point unit, so only one complex-integer or floating-point operation leaves per cycle. Port 1 takes simple integer work only. Ports 2, 3 and 4 each serve a single memory class. Simple integer operations go to port 1 first. Port 0 receives a simple operation only when it is older than every complex or floating-point candidate and port 1 has already taken a different simple operation or is busy. An allocator writes new entries through a single allocation port and reads the occupancy vector to find free slots.

Top module: `uop_port_arbiter`

## Requirements
- R1: While reset is held, and once it has been released, until the first allocation, `entry_valid` is all zero and no `grant_vld` bit is set.
- R2: An allocation with `alloc_en` high writes class and age into slot `alloc_idx` and sets that slot's `entry_valid` bit at the next edge. A valid entry whose `ready_vec` bit is low is never granted.
- R3: Among the candidates of one port, the entry with the lowest age value wins. On equal ages, the lower slot index wins.
- R4: Class codes are 0 complex integer, 1 simple integer, 2 floating point, 3 load, 4 store address, 5 store data. Port 0 takes codes 0, 2 and 1. Port 1 takes code 1 only. Ports 2, 3 and 4 take codes 3, 4 and 5 respectively.
- R5: Port 0 grants at most one entry per cycle, so a complex-integer and a floating-point operation never leave together. Two integer operations, or one integer and one floating-point operation, can leave in one cycle.
- R6: The oldest ready simple-integer entry goes to port 1. Port 0 grants a simple entry only if port 1 has taken another one or is busy.
- R7: A port whose `port_busy` bit is high gets no grant that cycle, and its candidates stay valid.
- R8: No slot is granted to two ports in the same cycle.
- R9: Every granted slot has its `entry_valid` bit cleared at the next edge. Slots not granted keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| alloc_en | input | 1 | Write one entry this cycle |
| alloc_idx | input | IDX_W | Slot to write |
| alloc_cls | input | 3 | Operation class code of the new entry |
| alloc_age | input | AGE_W | Age of the new entry, lower is older |
| ready_vec | input | ENTRIES | Per-slot operands-ready flags |
| port_busy | input | 5 | Per-port stall; bit n stalls port n |
| grant_vld | output | 5 | Per-port dispatch flag |
| grant_idx | output | 5*IDX_W | Per-port granted slot; port n at bits n*IDX_W upward |
| entry_valid | output | ENTRIES | Slot occupancy |

## Verification
The bench builds the block with its defaults: eight slots and a 4-bit age. This is enough to fill every port at once and to put two simple operations and a complex one into the pool together. It is also enough to build equal-age ties between a complex and a floating-point entry, which exercise the index tie-break on the shared port. Busy patterns that stall port 1 push a simple operation over to port 0. Busy patterns that stall the memory ports show that their candidates survive to a later cycle.

// File: rtl/uop_arb_pkg.sv
package uop_arb_pkg;

  localparam int NUM_PORTS = 5;
  localparam int CLS_W     = 3;

  typedef enum logic [CLS_W-1:0] {
    UC_CPLX = 3'd0,
    UC_SIMP = 3'd1,
    UC_FP   = 3'd2,
    UC_LOAD = 3'd3,
    UC_STA  = 3'd4,
    UC_STD  = 3'd5
  } uop_cls_e;

  localparam int PORT_SHARED = 0;
  localparam int PORT_SIMPLE = 1;
  localparam int PORT_LOAD   = 2;
  localparam int PORT_STA    = 3;
  localparam int PORT_STD    = 4;

  // Home port of each class; simple ops spill to the shared port in the top.
  function automatic logic [NUM_PORTS-1:0] home_port(logic [CLS_W-1:0] cls);
    logic [NUM_PORTS-1:0] m;
    m = '0;
    case (cls)
      UC_CPLX, UC_FP: m[PORT_SHARED] = 1'b1;
      UC_SIMP:        m[PORT_SIMPLE] = 1'b1;
      UC_LOAD:        m[PORT_LOAD]   = 1'b1;
      UC_STA:         m[PORT_STA]    = 1'b1;
      UC_STD:         m[PORT_STD]    = 1'b1;
      default:        m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/uarb_rst_sync.sv
module uarb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/uarb_entry_store.sv
module uarb_entry_store
  import uop_arb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AGE_W   = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_en,
  input  logic [IDX_W-1:0]                 alloc_idx,
  input  logic [CLS_W-1:0]                 alloc_cls,
  input  logic [AGE_W-1:0]                 alloc_age,
  input  logic [ENTRIES-1:0]               free_mask,
  output logic [ENTRIES-1:0]               valid_q,
  output logic [ENTRIES-1:0][CLS_W-1:0]    cls_q,
  output logic [ENTRIES-1:0][AGE_W-1:0]    age_q
);

  logic [ENTRIES-1:0] wr_en;
  logic [ENTRIES-1:0] valid_d;

  // One write strobe per slot; a write wins over a same-cycle free.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      wr_en[i]   = alloc_en && (alloc_idx == IDX_W'(i));
      valid_d[i] = wr_en[i] | (valid_q[i] & ~free_mask[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Payload registers: no reset, written under their own enable.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        cls_q[g] <= alloc_cls;
        age_q[g] <= alloc_age;
      end
    end
  end

endmodule

// File: rtl/uarb_elig_decode.sv
module uarb_elig_decode
  import uop_arb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic [ENTRIES-1:0]                 valid_q,
  input  logic [ENTRIES-1:0]                 ready_vec,
  input  logic [ENTRIES-1:0][CLS_W-1:0]      cls_q,
  output logic [NUM_PORTS-1:0][ENTRIES-1:0]  port_cand
);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [NUM_PORTS-1:0] home;
      home = home_port(cls_q[i]);
      for (int p = 0; p < NUM_PORTS; p++) begin
        port_cand[p][i] = valid_q[i] & ready_vec[i] & home[p];
      end
    end
  end

endmodule

// File: rtl/uarb_oldest_pick.sv
module uarb_oldest_pick #(
  parameter int ENTRIES = 8,
  parameter int AGE_W   = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             elig,
  input  logic [ENTRIES-1:0][AGE_W-1:0]  age,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx
);

  logic [AGE_W-1:0] best;

  // Strict compare keeps the lower index on equal ages.
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (elig[i] && (!hit || (age[i] < best))) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        best = age[i];
      end
    end
  end

endmodule

// File: rtl/uop_port_arbiter.sv
module uop_port_arbiter
  import uop_arb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AGE_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_en,
  input  logic [IDX_W-1:0]           alloc_idx,
  input  logic [CLS_W-1:0]           alloc_cls,
  input  logic [AGE_W-1:0]           alloc_age,
  input  logic [ENTRIES-1:0]         ready_vec,
  input  logic [NUM_PORTS-1:0]       port_busy,
  output logic [NUM_PORTS-1:0]       grant_vld,
  output logic [NUM_PORTS*IDX_W-1:0] grant_idx,
  output logic [ENTRIES-1:0]         entry_valid
);

  logic                               rst_n_sync;
  logic [ENTRIES-1:0]                 valid_q;
  logic [ENTRIES-1:0][CLS_W-1:0]      ent_cls;
  logic [ENTRIES-1:0][AGE_W-1:0]      ent_age;
  logic [NUM_PORTS-1:0][ENTRIES-1:0]  port_cand;
  logic [ENTRIES-1:0]                 free_mask;

  logic [NUM_PORTS-1:1]               sec_hit;
  logic [IDX_W-1:0]                   sec_idx [NUM_PORTS-1:1];
  logic [ENTRIES-1:0]                 sec_elig [NUM_PORTS-1:1];

  logic                               p0_hit;
  logic [IDX_W-1:0]                   p0_idx;
  logic [ENTRIES-1:0]                 p0_elig;
  logic [ENTRIES-1:0]                 p1_taken;

  uarb_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  uarb_entry_store #(
    .ENTRIES (ENTRIES),
    .AGE_W   (AGE_W),
    .IDX_W   (IDX_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .alloc_en  (alloc_en),
    .alloc_idx (alloc_idx),
    .alloc_cls (alloc_cls),
    .alloc_age (alloc_age),
    .free_mask (free_mask),
    .valid_q   (valid_q),
    .cls_q     (ent_cls),
    .age_q     (ent_age)
  );

  uarb_elig_decode #(
    .ENTRIES (ENTRIES)
  ) i_decode (
    .valid_q   (valid_q),
    .ready_vec (ready_vec),
    .cls_q     (ent_cls),
    .port_cand (port_cand)
  );

  // Dedicated ports 1..4 pick from their own class only.
  for (genvar p = 1; p < NUM_PORTS; p++) begin : g_port
    assign sec_elig[p] = port_cand[p] & {ENTRIES{~port_busy[p]}};

    uarb_oldest_pick #(
      .ENTRIES (ENTRIES),
      .AGE_W   (AGE_W),
      .IDX_W   (IDX_W)
    ) i_pick (
      .elig (sec_elig[p]),
      .age  (ent_age),
      .hit  (sec_hit[p]),
      .idx  (sec_idx[p])
    );
  end

  // Shared port: complex/FP plus whatever simple work port 1 left behind.
  always_comb begin
    p1_taken = '0;
    if (sec_hit[PORT_SIMPLE]) p1_taken[sec_idx[PORT_SIMPLE]] = 1'b1;
    p0_elig = (port_cand[PORT_SHARED] | (port_cand[PORT_SIMPLE] & ~p1_taken))
              & {ENTRIES{~port_busy[PORT_SHARED]}};
  end

  uarb_oldest_pick #(
    .ENTRIES (ENTRIES),
    .AGE_W   (AGE_W),
    .IDX_W   (IDX_W)
  ) i_pick_shared (
    .elig (p0_elig),
    .age  (ent_age),
    .hit  (p0_hit),
    .idx  (p0_idx)
  );

  always_comb begin
    grant_vld = '0;
    grant_idx = '0;
    free_mask = '0;
    grant_vld[PORT_SHARED] = p0_hit;
    if (p0_hit) begin
      grant_idx[PORT_SHARED*IDX_W +: IDX_W] = p0_idx;
      free_mask[p0_idx] = 1'b1;
    end
    for (int p = 1; p < NUM_PORTS; p++) begin
      grant_vld[p] = sec_hit[p];
      if (sec_hit[p]) begin
        grant_idx[p*IDX_W +: IDX_W] = sec_idx[p];
        free_mask[sec_idx[p]] = 1'b1;
      end
    end
  end

  assign entry_valid = valid_q;

endmodule

// File: rtl/uarb_checker.sv
module uarb_checker
  import uop_arb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AGE_W   = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       alloc_en,
  input logic [IDX_W-1:0]           alloc_idx,
  input logic [ENTRIES-1:0]         ready_vec,
  input logic [NUM_PORTS-1:0]       port_busy,
  input logic [NUM_PORTS-1:0]       grant_vld,
  input logic [NUM_PORTS*IDX_W-1:0] grant_idx,
  input logic [ENTRIES-1:0]         entry_valid,
  input logic [ENTRIES-1:0][CLS_W-1:0] ent_cls
);

  logic [IDX_W-1:0]     gidx [NUM_PORTS];
  logic [NUM_PORTS-1:0] cls_ok;
  logic                 p0_simple;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      gidx[p] = grant_idx[p*IDX_W +: IDX_W];
      case (ent_cls[gidx[p]])
        3'd0, 3'd2: cls_ok[p] = (p == 0);
        3'd1:       cls_ok[p] = (p == 0) || (p == 1);
        3'd3:       cls_ok[p] = (p == 2);
        3'd4:       cls_ok[p] = (p == 3);
        3'd5:       cls_ok[p] = (p == 4);
        default:    cls_ok[p] = 1'b0;
      endcase
    end
    p0_simple = (ent_cls[gidx[0]] == 3'd1);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R2: only valid, ready slots leave
    a_r2_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld[p] |-> (entry_valid[gidx[p]] && ready_vec[gidx[p]]));
    // R4: class matches port capability
    a_r4_port_class: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld[p] |-> cls_ok[p]);
    // R7: stalled port is idle
    a_r7_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
      port_busy[p] |-> !grant_vld[p]);
    // R9: granted slot is freed at the next edge unless rewritten
    a_r9_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld[p] && !(alloc_en && alloc_idx == gidx[p]))
        |=> !entry_valid[$past(gidx[p])]);
    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      // R8: no slot on two ports
      a_r8_unique_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld[p] && grant_vld[q]) |-> (gidx[p] != gidx[q]));
    end
  end

  // R6: simple work reaches the shared port only when port 1 is used or stalled
  a_r6_simple_spill: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld[0] && p0_simple) |-> (grant_vld[1] || port_busy[1]));

endmodule

bind uop_port_arbiter uarb_checker #(
  .ENTRIES (ENTRIES),
  .AGE_W   (AGE_W),
  .IDX_W   (IDX_W)
) i_uarb_checker (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .alloc_en    (alloc_en),
  .alloc_idx   (alloc_idx),
  .ready_vec   (ready_vec),
  .port_busy   (port_busy),
  .grant_vld   (grant_vld),
  .grant_idx   (grant_idx),
  .entry_valid (entry_valid),
  .ent_cls     (ent_cls)
);

// File: tb/test_uop_port_arbiter.sv
module test_uop_port_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 8;
  localparam int AGE_W      = 4;
  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int NP         = 5;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  alloc_en;
  logic [IDX_W-1:0]      alloc_idx;
  logic [2:0]            alloc_cls;
  logic [AGE_W-1:0]      alloc_age;
  logic [ENTRIES-1:0]    ready_vec;
  logic [NP-1:0]         port_busy;
  logic [NP-1:0]         grant_vld;
  logic [NP*IDX_W-1:0]   grant_idx;
  logic [ENTRIES-1:0]    entry_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_port_arbiter #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) i_uop_port_arbiter (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .alloc_cls(alloc_cls), .alloc_age(alloc_age), .ready_vec(ready_vec),
    .port_busy(port_busy), .grant_vld(grant_vld), .grant_idx(grant_idx),
    .entry_valid(entry_valid)
  );

  task automatic chk_port(input int p, input bit ev, input int ei, input string tag);
    int ai;
    ai = int'(grant_idx[p*IDX_W +: IDX_W]);
    checks++;
    if (grant_vld[p] !== ev || (ev && ai != ei)) begin
      errors++;
      $display("FAIL %s port%0d: vld=%0b idx=%0d expected vld=%0b idx=%0d",
               tag, p, grant_vld[p], ai, ev, ei);
    end
  endtask

  task automatic chk_valid(input logic [ENTRIES-1:0] ev, input string tag);
    checks++;
    if (entry_valid !== ev) begin
      errors++;
      $display("FAIL %s entry_valid=%b expected %b", tag, entry_valid, ev);
    end
  endtask

  task automatic put(input int idx, input int cls, input int age);
    @(negedge clk);
    alloc_en  = 1'b1;
    alloc_idx = IDX_W'(idx);
    alloc_cls = 3'(cls);
    alloc_age = AGE_W'(age);
    @(posedge clk);
    #1;
    alloc_en  = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    ready_vec = '1;
    port_busy = '0;
    #1;
    chk_valid('0, "R1 reset");
    for (int p = 0; p < NP; p++) chk_port(p, 1'b0, 0, "R1 reset grant");
  endtask

  task automatic t_routing();
    ready_vec = '0;
    put(0, 3, 5); put(1, 4, 3); put(2, 5, 7); put(3, 1, 2); put(4, 0, 4);
    chk_valid(8'b0001_1111, "R2 alloc sets valid");
    for (int p = 0; p < NP; p++) chk_port(p, 1'b0, 0, "R2 not ready");
    ready_vec = '1;
    #1;
    chk_port(0, 1'b1, 4, "R4 complex on port0");
    chk_port(1, 1'b1, 3, "R4 simple on port1");
    chk_port(2, 1'b1, 0, "R4 load on port2");
    chk_port(3, 1'b1, 1, "R4 sta on port3");
    chk_port(4, 1'b1, 2, "R4 std on port4");
    step();
    chk_valid('0, "R9 all freed");
  endtask

  task automatic t_oldest();
    ready_vec = '0;
    put(0, 2, 9); put(1, 0, 6); put(2, 2, 6); put(3, 3, 8); put(5, 3, 1);
    ready_vec = '1;
    #1;
    chk_port(0, 1'b1, 1, "R3 tie lower index");
    chk_port(1, 1'b0, 0, "R5 port1 idle");
    chk_port(2, 1'b1, 5, "R3 oldest load");
    step();
    chk_valid(8'b0000_1101, "R9 partial free");
    chk_port(0, 1'b1, 2, "R5 one shared op per cycle");
    chk_port(2, 1'b1, 3, "R3 next load");
    step();
    chk_port(0, 1'b1, 0, "R5 last fp");
    chk_port(2, 1'b0, 0, "R3 loads drained");
    step();
    chk_valid('0, "R9 drained");
  endtask

  task automatic t_simple_pair();
    ready_vec = '0;
    put(0, 1, 3); put(1, 1, 1); put(2, 1, 5); put(3, 0, 4);
    ready_vec = '1;
    #1;
    chk_port(1, 1'b1, 1, "R6 oldest simple on port1");
    chk_port(0, 1'b1, 0, "R6 second simple on port0");
    step();
    chk_valid(8'b0000_1100, "R8 two distinct freed");
    chk_port(1, 1'b1, 2, "R6 remaining simple");
    chk_port(0, 1'b1, 3, "R5 complex with simple");
    step();
    chk_valid('0, "R9 pair drained");
  endtask

  task automatic t_busy();
    ready_vec = '0;
    put(0, 1, 2); put(1, 3, 1); put(2, 0, 3);
    ready_vec = '1;
    port_busy = 5'b00110;
    #1;
    chk_port(1, 1'b0, 0, "R7 port1 busy");
    chk_port(2, 1'b0, 0, "R7 port2 busy");
    chk_port(0, 1'b1, 0, "R6 simple spills when port1 busy");
    step();
    chk_valid(8'b0000_0110, "R7 busy candidate kept");
    port_busy = 5'b00001;
    #1;
    chk_port(0, 1'b0, 0, "R7 port0 busy");
    chk_port(2, 1'b1, 1, "R7 load after release");
    step();
    chk_valid(8'b0000_0100, "R7 complex kept");
    port_busy = '0;
    #1;
    chk_port(0, 1'b1, 2, "R7 complex after release");
    step();
    chk_valid('0, "R9 busy drained");
  endtask

  task automatic t_not_ready();
    ready_vec = '0;
    put(0, 3, 0); put(1, 3, 5);
    ready_vec = 8'b0000_0010;
    #1;
    chk_port(2, 1'b1, 1, "R2 older unready skipped");
    step();
    chk_valid(8'b0000_0001, "R2 unready stays");
    ready_vec = '1;
    #1;
    chk_port(2, 1'b1, 0, "R2 granted once ready");
    step();
    chk_valid('0, "R9 final");
  endtask

  initial begin
    rst_n     = 1'b0;
    alloc_en  = 1'b0;
    alloc_idx = '0;
    alloc_cls = '0;
    alloc_age = '0;
    ready_vec = '1;
    port_busy = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_routing();
    t_oldest();
    t_simple_pair();
    t_busy();
    t_not_ready();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule